// File: doc/BRIEF.md
# Trap Entry Unit

This block computes every machine-state change a hart makes when it enters a trap. A one-cycle strobe presents a trap request. The request carries:

- a request kind,
- a raw cause code,
- an interrupt flag,
- a fault address,
- the access type and whether address translation is on.

The surrounding control and status register file supplies the current PC and privilege, the status word, both delegation masks and both vector-base registers. From these the unit does four things:

- It resolves the final cause code.
- It decides whether supervisor or machine mode takes the trap.
- It rewrites the interrupt-enable stack in the status word.
- It computes the handler PC and the new privilege.

All results are registered. They appear together on the cycle after the strobe, marked by a one-cycle commit pulse, so the register file can write them in a single edge.

The strobe is a plain control input with no back-pressure. A request is accepted on every clock edge where `trap_valid_i` is high. There is no ready signal, because the commit always follows exactly one cycle later. Between commits the result outputs keep their last values.

Request kinds on `trap_kind_i`:

| Code | Kind | Cause code used |
|------|------|-----------------|
| 0 | raw | `trap_code_i`, with `trap_irq_i` honoured |
| 1 | environment call | derived from the privilege |
| 2 | translation failure | derived from the access type and translation state |
| 3 | raw | same as code 0 |

Access type codes on `acc_kind_i`:

| Code | Access |
|------|--------|
| 0 | fetch |
| 1 | load |
| 2 | store |
| 3 | store |

Privilege codes: 0 is user, 1 is supervisor, 3 is machine.

Top module: `trap_entry_unit`

## Requirements
- R1: The delegation mask is `mideleg_i` when the resolved trap is an interrupt and `medeleg_i` when it is an exception. Kinds 1 and 2 are always exceptions.
- R2: The trap goes to supervisor mode when both of these hold; otherwise it goes to machine mode (`to_smode_o` = 0):
  - the current privilege is 0 or 1;
  - the mask bit indexed by the resolved cause code is 1.
- R3: On supervisor entry the status word changes as follows, and every other bit is unchanged:
  - bit 5 takes the old bit 1;
  - bit 8 takes bit 0 of the current privilege;
  - bit 1 becomes 0.
- R4: On machine entry the status word changes as follows, and every other bit is unchanged:
  - bit 7 takes the old bit 3;
  - bits 12:11 take the current privilege;
  - bit 3 becomes 0.
- R5: `cause_o` holds the resolved code in its low bits and zeros above them. Bit XLEN-1 is set only for an interrupt.
- R6: `new_pc_o` is the chosen mode's vector register with bits 1:0 cleared. When that register's bits 1:0 equal 1 and the trap is an interrupt, the resolved code times 4 is added.
- R7: `tval_o` equals `fault_addr_i` for exceptions with codes 0, 1, 4, 5, 6, 7, 12, 13 and 15. For every other exception and for every interrupt it is 0.
- R8: An environment call (kind 1) resolves to code 8 from user, 9 from supervisor, 10 from privilege 2 and 11 from machine.
- R9: A translation failure (kind 2) resolves to a page fault when `xlat_on_i` is 1: 12 for fetch, 13 for load, 15 for store. When `xlat_on_i` is 0 it resolves to an access fault: 1, 5 and 7 respectively.
- R10: `epc_o` equals the `cur_pc_i` sampled with the strobe. `new_priv_o` is 1 for supervisor entry and 3 for machine entry.
- R11: `commit_o` is high for exactly the cycle after each edge where `trap_valid_i` is high. With no strobe, all result outputs hold their values.
- R12: While reset is held, `commit_o` is 0, `new_priv_o` is 3 and every other result output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_valid_i | input | 1 | Trap request strobe |
| trap_kind_i | input | 2 | Request kind (0 raw, 1 environment call, 2 translation failure, 3 raw) |
| trap_irq_i | input | 1 | Raw request is an interrupt |
| trap_code_i | input | CODE_W | Raw cause code |
| acc_kind_i | input | 2 | Access type for translation failures |
| xlat_on_i | input | 1 | Address translation active |
| fault_addr_i | input | XLEN | Faulting address |
| cur_pc_i | input | XLEN | PC of the trapping instruction |
| cur_priv_i | input | 2 | Current privilege |
| mstatus_i | input | XLEN | Current status word |
| medeleg_i | input | XLEN | Exception delegation mask |
| mideleg_i | input | XLEN | Interrupt delegation mask |
| mtvec_i | input | XLEN | Machine vector register |
| stvec_i | input | XLEN | Supervisor vector register |
| commit_o | output | 1 | Results valid this cycle |
| to_smode_o | output | 1 | Supervisor mode takes the trap |
| new_priv_o | output | 2 | Privilege after entry |
| new_pc_o | output | XLEN | Handler PC |
| mstatus_o | output | XLEN | Updated status word |
| epc_o | output | XLEN | Value for the chosen mode's exception PC |
| cause_o | output | XLEN | Value for the chosen mode's cause register |
| tval_o | output | XLEN | Value for the chosen mode's trap-value register |

## Verification
The unit keeps no state between traps other than its output registers. A wrong routing decision, cause resolution or status rewrite therefore shows up on the commit cycle itself, exactly one clock after the strobe. The error is visible together in `to_smode_o`, `new_priv_o`, `mstatus_o` and `new_pc_o`. A fault in the hold path instead shows as output values changing on a cycle without a strobe, or as a commit pulse with no request behind it. The bench compares every output field on every commit. It also probes the idle cycles that follow a commit while the inputs change.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_R = 2'd2,
    PRIV_M = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    KIND_RAW  = 2'd0,
    KIND_ECALL = 2'd1,
    KIND_XLAT = 2'd2,
    KIND_RAW2 = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_ST2   = 2'd3
  } acc_e;

  // Status word bit positions; the register file decodes these.
  localparam int unsigned ST_SIE  = 1;
  localparam int unsigned ST_MIE  = 3;
  localparam int unsigned ST_SPIE = 5;
  localparam int unsigned ST_MPIE = 7;
  localparam int unsigned ST_SPP  = 8;
  localparam int unsigned ST_MPP  = 11;

  localparam int unsigned ECALL_BASE = 8;
  localparam int unsigned PF_FETCH = 12;
  localparam int unsigned PF_LOAD  = 13;
  localparam int unsigned PF_STORE = 15;
  localparam int unsigned AF_FETCH = 1;
  localparam int unsigned AF_LOAD  = 5;
  localparam int unsigned AF_STORE = 7;

  // Exception codes that carry an address in the trap-value register.
  function automatic logic code_has_addr(input logic [7:0] code);
    case (code)
      8'd0, 8'd1, 8'd4, 8'd5, 8'd6, 8'd7, 8'd12, 8'd13, 8'd15: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/trap_cause_resolve.sv
module trap_cause_resolve
  import trap_entry_pkg::*;
#(
  parameter int unsigned CODE_W = 5
) (
  input  logic [1:0]        kind_i,
  input  logic              irq_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [1:0]        acc_i,
  input  logic              xlat_on_i,
  input  logic [1:0]        priv_i,
  output logic [CODE_W-1:0] code_o,
  output logic              irq_o,
  output logic              has_addr_o
);

  logic [CODE_W-1:0] xlat_code;

  always_comb begin
    unique case (acc_e'(acc_i))
      ACC_FETCH: xlat_code = xlat_on_i ? CODE_W'(PF_FETCH) : CODE_W'(AF_FETCH);
      ACC_LOAD:  xlat_code = xlat_on_i ? CODE_W'(PF_LOAD)  : CODE_W'(AF_LOAD);
      default:   xlat_code = xlat_on_i ? CODE_W'(PF_STORE) : CODE_W'(AF_STORE);
    endcase
  end

  always_comb begin
    unique case (kind_e'(kind_i))
      KIND_ECALL: begin
        // privilege occupies the two low bits above the base of 8
        code_o = CODE_W'(ECALL_BASE) | CODE_W'(priv_i);
        irq_o  = 1'b0;
      end
      KIND_XLAT: begin
        code_o = xlat_code;
        irq_o  = 1'b0;
      end
      default: begin
        code_o = code_i;
        irq_o  = irq_i;
      end
    endcase
  end

  assign has_addr_o = !irq_o && code_has_addr(8'(code_o));

endmodule

// File: rtl/trap_route.sv
module trap_route
  import trap_entry_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CODE_W = 5
) (
  input  logic              irq_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [1:0]        priv_i,
  input  logic [XLEN-1:0]   medeleg_i,
  input  logic [XLEN-1:0]   mideleg_i,
  output logic              to_s_o
);

  logic [XLEN-1:0] mask;
  logic            low_priv;

  assign mask     = irq_i ? mideleg_i : medeleg_i;
  assign low_priv = (priv_e'(priv_i) == PRIV_U) || (priv_e'(priv_i) == PRIV_S);
  assign to_s_o   = low_priv && mask[code_i];

endmodule

// File: rtl/trap_vector_calc.sv
module trap_vector_calc #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CODE_W = 5
) (
  input  logic              to_s_i,
  input  logic              irq_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   stvec_i,
  input  logic [XLEN-1:0]   mtvec_i,
  output logic [XLEN-1:0]   pc_o
);

  localparam logic [1:0] MODE_VECTORED = 2'd1;

  logic [XLEN-1:0] tvec;
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  assign tvec   = to_s_i ? stvec_i : mtvec_i;
  assign base   = {tvec[XLEN-1:2], 2'b00};
  assign offset = (irq_i && tvec[1:0] == MODE_VECTORED) ? (XLEN'(code_i) << 2) : '0;
  assign pc_o   = base + offset;

endmodule

// File: rtl/trap_status_update.sv
module trap_status_update
  import trap_entry_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            to_s_i,
  input  logic [1:0]      priv_i,
  input  logic [XLEN-1:0] status_i,
  output logic [XLEN-1:0] status_o
);

  always_comb begin
    status_o = status_i;
    if (to_s_i) begin
      status_o[ST_SPIE] = status_i[ST_SIE];
      status_o[ST_SPP]  = priv_i[0];
      status_o[ST_SIE]  = 1'b0;
    end else begin
      status_o[ST_MPIE]          = status_i[ST_MIE];
      status_o[ST_MPP +: 2]      = priv_i;
      status_o[ST_MIE]           = 1'b0;
    end
  end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_entry_pkg::*;
#(
  parameter  int unsigned XLEN   = 32,
  localparam int unsigned CODE_W = $clog2(XLEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_valid_i,
  input  logic [1:0]        trap_kind_i,
  input  logic              trap_irq_i,
  input  logic [CODE_W-1:0] trap_code_i,
  input  logic [1:0]        acc_kind_i,
  input  logic              xlat_on_i,
  input  logic [XLEN-1:0]   fault_addr_i,
  input  logic [XLEN-1:0]   cur_pc_i,
  input  logic [1:0]        cur_priv_i,
  input  logic [XLEN-1:0]   mstatus_i,
  input  logic [XLEN-1:0]   medeleg_i,
  input  logic [XLEN-1:0]   mideleg_i,
  input  logic [XLEN-1:0]   mtvec_i,
  input  logic [XLEN-1:0]   stvec_i,
  output logic              commit_o,
  output logic              to_smode_o,
  output logic [1:0]        new_priv_o,
  output logic [XLEN-1:0]   new_pc_o,
  output logic [XLEN-1:0]   mstatus_o,
  output logic [XLEN-1:0]   epc_o,
  output logic [XLEN-1:0]   cause_o,
  output logic [XLEN-1:0]   tval_o
);

  logic [CODE_W-1:0] fin_code;
  logic              fin_irq;
  logic              has_addr;
  logic              to_s;
  logic [XLEN-1:0]   pc_d;
  logic [XLEN-1:0]   status_d;
  logic [XLEN-1:0]   cause_d;
  logic [XLEN-1:0]   tval_d;

  trap_cause_resolve #(.CODE_W(CODE_W)) u_resolve (
    .kind_i    (trap_kind_i),
    .irq_i     (trap_irq_i),
    .code_i    (trap_code_i),
    .acc_i     (acc_kind_i),
    .xlat_on_i (xlat_on_i),
    .priv_i    (cur_priv_i),
    .code_o    (fin_code),
    .irq_o     (fin_irq),
    .has_addr_o(has_addr)
  );

  trap_route #(.XLEN(XLEN), .CODE_W(CODE_W)) u_route (
    .irq_i    (fin_irq),
    .code_i   (fin_code),
    .priv_i   (cur_priv_i),
    .medeleg_i(medeleg_i),
    .mideleg_i(mideleg_i),
    .to_s_o   (to_s)
  );

  trap_vector_calc #(.XLEN(XLEN), .CODE_W(CODE_W)) u_vector (
    .to_s_i (to_s),
    .irq_i  (fin_irq),
    .code_i (fin_code),
    .stvec_i(stvec_i),
    .mtvec_i(mtvec_i),
    .pc_o   (pc_d)
  );

  trap_status_update #(.XLEN(XLEN)) u_status (
    .to_s_i  (to_s),
    .priv_i  (cur_priv_i),
    .status_i(mstatus_i),
    .status_o(status_d)
  );

  always_comb begin
    cause_d           = XLEN'(fin_code);
    cause_d[XLEN-1]   = fin_irq;
  end

  assign tval_d = has_addr ? fault_addr_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_o   <= 1'b0;
      to_smode_o <= 1'b0;
      new_priv_o <= PRIV_M;
      new_pc_o   <= '0;
      mstatus_o  <= '0;
      epc_o      <= '0;
      cause_o    <= '0;
      tval_o     <= '0;
    end else begin
      commit_o <= trap_valid_i;
      if (trap_valid_i) begin
        to_smode_o <= to_s;
        new_priv_o <= to_s ? PRIV_S : PRIV_M;
        new_pc_o   <= pc_d;
        mstatus_o  <= status_d;
        epc_o      <= cur_pc_i;
        cause_o    <= cause_d;
        tval_o     <= tval_d;
      end
    end
  end

  // Commit strobe follows every request by one cycle (R11)
  assert_commit_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid_i |=> commit_o);
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid_i |=> (!commit_o && $stable(new_pc_o) && $stable(cause_o) && $stable(epc_o)));
  // Machine privilege never delegates (R2)
  assert_mmode_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid_i && cur_priv_i == PRIV_M) |=> !to_smode_o);
  // Supervisor entry clears SIE and lands in S (R3)
  assert_s_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_o && to_smode_o) |-> (!mstatus_o[ST_SIE] && new_priv_o == PRIV_S));
  // Machine entry clears MIE and lands in M (R4)
  assert_m_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_o && !to_smode_o) |-> (!mstatus_o[ST_MIE] && new_priv_o == PRIV_M));
  // Handler PC stays word aligned (R6)
  assert_pc_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> (new_pc_o[1:0] == 2'b00));
  // Interrupts carry no trap value (R7)
  assert_irq_tval_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_o && cause_o[XLEN-1]) |-> (tval_o == '0));
  // Environment calls never flag as interrupts (R8)
  assert_ecall_not_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid_i && trap_kind_i == KIND_ECALL) |=> !cause_o[XLEN-1]);
  // Exception PC is the sampled instruction PC (R10)
  assert_epc_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid_i |=> (epc_o == $past(cur_pc_i)));

endmodule

// File: tb/trap_entry_unit_tb_top.sv
module trap_entry_unit_tb_top;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic trap_valid = 1'b0;
  logic [1:0] kind = '0;
  logic irq = 1'b0;
  logic [4:0] code = '0;
  logic [1:0] acc = '0;
  logic xlat = 1'b0;
  logic [XLEN-1:0] addr = '0, pc = '0, ms = '0, med = '0, mid = '0, mt = '0, st = '0;
  logic [1:0] priv = '0;

  logic commit, to_s;
  logic [1:0] npriv;
  logic [XLEN-1:0] npc, nms, epc, cause, tval;

  trap_entry_unit #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .trap_valid_i(trap_valid), .trap_kind_i(kind),
    .trap_irq_i(irq), .trap_code_i(code), .acc_kind_i(acc), .xlat_on_i(xlat),
    .fault_addr_i(addr), .cur_pc_i(pc), .cur_priv_i(priv), .mstatus_i(ms),
    .medeleg_i(med), .mideleg_i(mid), .mtvec_i(mt), .stvec_i(st),
    .commit_o(commit), .to_smode_o(to_s), .new_priv_o(npriv), .new_pc_o(npc),
    .mstatus_o(nms), .epc_o(epc), .cause_o(cause), .tval_o(tval)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct packed {
    logic            s;
    logic [1:0]      pr;
    logic [XLEN-1:0] pc, ms, epc, cause, tval;
  } exp_t;

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model built from the requirements
  function automatic exp_t model();
    exp_t e;
    logic [4:0] c;
    logic i;
    logic [XLEN-1:0] dm, tv;
    i = irq;
    c = code;
    if (kind == 2'd1) begin            // R8
      i = 1'b0;
      c = 5'd8 + {3'b0, priv};
    end else if (kind == 2'd2) begin   // R9
      i = 1'b0;
      if (xlat) c = (acc == 2'd0) ? 5'd12 : (acc == 2'd1) ? 5'd13 : 5'd15;
      else      c = (acc == 2'd0) ? 5'd1  : (acc == 2'd1) ? 5'd5  : 5'd7;
    end
    dm = i ? mid : med;                // R1
    e.s = (priv <= 2'd1) && dm[c];     // R2
    e.pr = e.s ? 2'd1 : 2'd3;
    e.ms = ms;
    if (e.s) begin
      e.ms[5] = ms[1]; e.ms[8] = priv[0]; e.ms[1] = 1'b0;
    end else begin
      e.ms[7] = ms[3]; e.ms[12:11] = priv; e.ms[3] = 1'b0;
    end
    tv = e.s ? st : mt;
    e.pc = {tv[XLEN-1:2], 2'b00} + ((i && tv[1:0] == 2'd1) ? {25'd0, c, 2'b00} : '0);
    e.epc = pc;
    e.cause = {i, 26'd0, c};
    e.tval = (!i && (c inside {5'd0, 5'd1, 5'd4, 5'd5, 5'd6, 5'd7, 5'd12, 5'd13, 5'd15})) ? addr : '0;
    return e;
  endfunction

  exp_t last;

  task automatic check_all(input string ctx, input exp_t e);
    chk({ctx, " R11 commit"}, XLEN'(commit), 32'd1);
    chk({ctx, " R2 route"}, XLEN'(to_s), XLEN'(e.s));
    chk({ctx, " R10 priv"}, XLEN'(npriv), XLEN'(e.pr));
    chk({ctx, " R6 pc"}, npc, e.pc);
    chk({ctx, " R3 R4 status"}, nms, e.ms);
    chk({ctx, " R10 epc"}, epc, e.epc);
    chk({ctx, " R5 cause"}, cause, e.cause);
    chk({ctx, " R7 tval"}, tval, e.tval);
  endtask

  task automatic fire(input string ctx);
    exp_t e;
    e = model();
    trap_valid = 1'b1;
    @(negedge clk);
    trap_valid = 1'b0;
    check_all(ctx, e);
    last = e;
  endtask

  task automatic randomize_inputs();
    kind = 2'($urandom); irq = 1'($urandom); code = 5'($urandom);
    acc = 2'($urandom); xlat = 1'($urandom); priv = 2'($urandom);
    addr = $urandom; pc = $urandom; ms = $urandom;
    med = $urandom; mid = $urandom; mt = $urandom; st = $urandom;
  endtask

  task automatic hold_check();
    randomize_inputs();
    @(negedge clk);
    chk("R11 no commit when idle", XLEN'(commit), 32'd0);
    chk("R11 pc held", npc, last.pc);
    chk("R11 cause held", cause, last.cause);
    chk("R11 status held", nms, last.ms);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R11 watchdog actual=%0d expected<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7731));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 commit", XLEN'(commit), 32'd0);
    chk("R12 priv", XLEN'(npriv), 32'd3);
    chk("R12 pc", npc, 32'd0);
    chk("R12 cause", cause, 32'd0);
    chk("R12 tval", tval, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 environment calls from each privilege, no delegation
    med = '0; mid = '0; mt = 32'h8000_0101; st = 32'h4000_0201;
    ms = 32'h0000_00AA; addr = 32'hDEAD_BEEF; pc = 32'h1000;
    for (int p = 0; p < 4; p++) begin
      kind = 2'd1; priv = 2'(p);
      fire("R8 ecall");
    end
    // R8 delegated ecall from user lands in S
    med = 32'h0000_0100; priv = 2'd0; fire("R8 R2 ecall delegated");
    // R9 translation failure, all access types, translation on and off
    med = '0;
    for (int x = 0; x < 2; x++) begin
      for (int a = 0; a < 3; a++) begin
        kind = 2'd2; xlat = 1'(x); acc = 2'(a); priv = 2'd1;
        fire("R9 xlat fault");
      end
    end
    // R1 interrupt delegated by mideleg only; vectored S handler (R6)
    kind = 2'd0; irq = 1'b1; code = 5'd5; priv = 2'd1;
    mid = 32'h0000_0020; med = '0; ms = 32'h0000_0002;
    fire("R1 R6 irq delegated vectored");
    // R1 exception with same code uses medeleg: not delegated
    irq = 1'b0; fire("R1 exc not delegated");
    // R2 machine privilege ignores delegation
    irq = 1'b1; priv = 2'd3; mid = '1; med = '1; ms = 32'h0000_0008;
    fire("R2 R4 mmode irq");
    // R6 direct mode irq: no offset
    mt = 32'h8000_0100; priv = 2'd3; code = 5'd11; fire("R6 direct irq");
    // R7 illegal instruction code 2 gives zero tval
    irq = 1'b0; code = 5'd2; fire("R7 no addr code");
    hold_check();

    for (int t = 0; t < 1500; t++) begin
      randomize_inputs();
      fire("random");
      if ((t % 4) == 0) hold_check();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule